// File: doc/BRIEF.md
# Keypad Entry Buffer with Commit

This block scans a 4x4 matrix keypad and turns each accepted keystroke into a hex digit. The digits collect in a 32-bit entry buffer. The buffer is presented live on a display output, so the user can watch the number grow while typing.

The processor never sees this live buffer. It reads a separate read-data register, which is loaded from the buffer only when the debounced commit button is pressed. Key bounce and half-typed numbers therefore never reach software. A debounced clear button empties the buffer and leaves the committed value alone.

The block runs from a 25 MHz clock. The parameter defaults give a row slot of about 1 ms and a button settle time of about 10 ms.

Top module: `keypad_entry`

## Requirements
- R1: Exactly one row output is driven low at any time. The low row advances every SLOT_TICKS clock cycles in the order 0, 1, 2, 3, then wraps to 0. Row r corresponds to bit r of `row_drive_o`.
- R2: When row r is low and column bit c of `col_sense_i` reads low at the end of the slot, the key's digit is 4*r + c. If several columns are low, the lowest column wins. Within one full scan, the lowest row that shows a key wins.
- R3: An accepted digit shifts the buffer left by 4 bits and enters the low nibble. With NUM_DIGITS = 8, a ninth digit pushes the oldest digit out of the top.
- R4: A key is accepted only after two consecutive full scans report the same digit. A held key adds exactly one digit. Another digit is accepted only after two consecutive full scans in which no column read low.
- R5: `display_o` always shows the live entry buffer, not the committed value.
- R6: A debounced press of commit copies the buffer into `read_data_o` exactly once per press, using the buffer value from before any update made in the same cycle.
- R7: Without a commit, `read_data_o` keeps its last committed value, even while the buffer changes.
- R8: A debounced press of clear sets the entry buffer to zero and leaves `read_data_o` unchanged.
- R9: A button level change is acted on only after it has held for DEB_TICKS cycles. A pulse of a few cycles has no effect.
- R10: Reset sets the entry buffer and `read_data_o` to zero and drives row 0 low (`row_drive_o` = 4'b1110).
- R11: When commit and clear act in the same cycle, `read_data_o` receives the buffer as it was before the clear, and the buffer becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (25 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_drive_o | output | 4 | Row drives, active low, one at a time |
| col_sense_i | input | 4 | Column senses, low when a key in the driven row is pressed |
| commit_btn_i | input | 1 | Commit button, active high, raw |
| clear_btn_i | input | 1 | Clear button, active high, raw |
| display_o | output | 32 | Live entry buffer |
| read_data_o | output | 32 | Last committed buffer value |

## Verification
Commit and clear can act in the same cycle, and so can commit and the acceptance of a key. The bench provokes the first case by raising both buttons on the same bench cycle. Both debouncers have identical timing, so their press pulses coincide. The bench then requires that the read data holds the pre-clear digits and that the display is zero. For the second case, the bench holds commit down while a key is accepted. It requires that the read data does not follow the new digit, because a held button must not act a second time.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int ROW_W = 2;
    localparam int COL_W = 2;

    // index of lowest column reading low (columns are active low)
    function automatic logic [COL_W-1:0] lowest_low_col(input logic [COLS-1:0] cols);
        logic [COL_W-1:0] idx;
        idx = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (!cols[c]) idx = c[COL_W-1:0];
        end
        return idx;
    endfunction
endpackage

// File: rtl/kp_debounce.sv
module kp_debounce #(
    parameter int DEB_TICKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic press_o
);
    localparam int CNT_W = (DEB_TICKS > 2) ? $clog2(DEB_TICKS) : 1;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             level;
        logic [CNT_W-1:0] cnt;
        logic             press;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = raw_i;
        st_d.s2    = st_q.s1;
        st_d.press = 1'b0;
        if (st_q.s2 != st_q.level) begin
            if (st_q.cnt == CNT_W'(DEB_TICKS - 1)) begin
                st_d.level = st_q.s2;
                st_d.cnt   = '0;
                st_d.press = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign press_o = st_q.press;

    // R9: settled level moves only after the synchronized input disagreed for the full window
    p_settle_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |->
            (($past(st_q.s2) != $past(st_q.level)) && ($past(st_q.cnt) == CNT_W'(DEB_TICKS - 1))));

    // R6: a press yields a single-cycle pulse
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o);
endmodule

// File: rtl/kp_scan.sv
module kp_scan
    import kp_pkg::*;
#(
    parameter int SLOT_TICKS = 25000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_i,
    output logic [ROWS-1:0] row_o,
    output logic            key_vld_o,
    output logic [3:0]      key_code_o
);
    localparam int TICK_W = $clog2(SLOT_TICKS);

    typedef struct packed {
        logic [COLS-1:0]   c1;
        logic [COLS-1:0]   c2;
        logic [TICK_W-1:0] tick;
        logic [ROW_W-1:0]  row;
        logic              frame_hit;
        logic [3:0]        frame_code;
        logic              cand_vld;
        logic [3:0]        cand_code;
        logic              armed;
        logic              quiet;
        logic              key_vld;
        logic [3:0]        key_code;
    } scan_t;

    scan_t st_d, st_q;
    logic       hit_now, fhit;
    logic [3:0] code_now, fcode;

    always_comb begin
        st_d         = st_q;
        st_d.c1      = col_i;
        st_d.c2      = st_q.c1;
        st_d.key_vld = 1'b0;
        hit_now      = ~&st_q.c2;
        code_now     = {st_q.row, lowest_low_col(st_q.c2)};
        fhit         = st_q.frame_hit | hit_now;
        fcode        = st_q.frame_hit ? st_q.frame_code : code_now;
        if (st_q.tick != TICK_W'(SLOT_TICKS - 1)) begin
            st_d.tick = st_q.tick + 1'b1;
        end else begin
            st_d.tick = '0;
            st_d.row  = st_q.row + 1'b1;
            if (st_q.row == ROW_W'(ROWS - 1)) begin
                st_d.frame_hit = 1'b0;
                if (!fhit) begin
                    st_d.cand_vld = 1'b0;
                    st_d.quiet    = 1'b1;
                    if (st_q.quiet) st_d.armed = 1'b1;
                end else begin
                    st_d.quiet = 1'b0;
                    if (!st_q.armed) begin
                        st_d.cand_vld = 1'b0;
                    end else if (st_q.cand_vld && st_q.cand_code == fcode) begin
                        st_d.key_vld  = 1'b1;
                        st_d.key_code = fcode;
                        st_d.armed    = 1'b0;
                        st_d.cand_vld = 1'b0;
                    end else begin
                        st_d.cand_vld  = 1'b1;
                        st_d.cand_code = fcode;
                    end
                end
            end else begin
                st_d.frame_hit  = fhit;
                st_d.frame_code = fcode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.c1    <= '1;
            st_q.c2    <= '1;
            st_q.armed <= 1'b1;
            st_q.quiet <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o      = ~(ROWS'(1) << st_q.row);
    assign key_vld_o  = st_q.key_vld;
    assign key_code_o = st_q.key_code;

    // R1: whenever the driven row changes, it moves to the next row in rotation
    p_row_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o != $past(row_o)) |-> (row_o == {$past(row_o[ROWS-2:0]), $past(row_o[ROWS-1])}));

    // R1: one row low at all times
    p_one_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_o) == 1);

    // R4: a held key produces one acceptance, never two in a row
    p_key_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld_o |=> !key_vld_o);
endmodule

// File: rtl/kp_accum.sv
module kp_accum #(
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    key_vld_i,
    input  logic [3:0]              key_code_i,
    input  logic                    commit_i,
    input  logic                    clear_i,
    output logic [4*NUM_DIGITS-1:0] buf_o,
    output logic [4*NUM_DIGITS-1:0] rd_o
);
    localparam int BUF_W = 4 * NUM_DIGITS;

    typedef struct packed {
        logic [BUF_W-1:0] entry;
        logic [BUF_W-1:0] held;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) st_d.held = st_q.entry;
        if (clear_i) begin
            st_d.entry = '0;
        end else if (key_vld_i) begin
            st_d.entry = {st_q.entry[BUF_W-5:0], key_code_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_o = st_q.entry;
    assign rd_o  = st_q.held;

    // R6 / R11: commit captures the buffer seen before the cycle's update
    p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (rd_o == $past(buf_o)));

    // R7: read data holds without a commit
    p_hold_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(rd_o));

    // R8: clear empties the buffer
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (buf_o == '0));

    // R3: an accepted digit shifts in at the low nibble
    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld_i && !clear_i) |=> (buf_o == {$past(buf_o[BUF_W-5:0]), $past(key_code_i)}));
endmodule

// File: rtl/keypad_entry.sv
module keypad_entry #(
    parameter int SLOT_TICKS = 25000,
    parameter int DEB_TICKS  = 250000,
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [3:0]              row_drive_o,
    input  logic [3:0]              col_sense_i,
    input  logic                    commit_btn_i,
    input  logic                    clear_btn_i,
    output logic [4*NUM_DIGITS-1:0] display_o,
    output logic [4*NUM_DIGITS-1:0] read_data_o
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_raw, btn_press;
    logic            key_vld;
    logic [3:0]      key_code;

    assign btn_raw = {clear_btn_i, commit_btn_i};

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        kp_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (btn_raw[b]),
            .press_o(btn_press[b])
        );
    end

    kp_scan #(.SLOT_TICKS(SLOT_TICKS)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_i     (col_sense_i),
        .row_o     (row_drive_o),
        .key_vld_o (key_vld),
        .key_code_o(key_code)
    );

    kp_accum #(.NUM_DIGITS(NUM_DIGITS)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_vld_i (key_vld),
        .key_code_i(key_code),
        .commit_i  (btn_press[0]),
        .clear_i   (btn_press[1]),
        .buf_o     (display_o),
        .rd_o      (read_data_o)
    );
endmodule

// File: tb/keypad_entry_bench.sv
module keypad_entry_bench;
    localparam int SLOT  = 8;
    localparam int DEB   = 4;
    localparam int FRAME = 4 * SLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_drive;
    logic [3:0]  col_sense;
    logic        commit_btn = 1'b0;
    logic        clear_btn = 1'b0;
    logic [31:0] display, read_data;
    logic [15:0] pressed = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_buf = '0;
    logic [31:0] exp_rd = '0;

    always #4 clk = ~clk;

    keypad_entry #(.SLOT_TICKS(SLOT), .DEB_TICKS(DEB), .NUM_DIGITS(8)) u_keypad_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_drive_o (row_drive),
        .col_sense_i (col_sense),
        .commit_btn_i(commit_btn),
        .clear_btn_i (clear_btn),
        .display_o   (display),
        .read_data_o (read_data)
    );

    // keypad matrix model: key 4r+c pulls column c low while row r is driven low
    always_comb begin
        col_sense = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (pressed[4*r+c] && !row_drive[r]) col_sense[c] = 1'b0;
    end

    function automatic logic [31:0] push(input logic [31:0] b, input logic [3:0] d);
        return {b[27:0], d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key(input logic [15:0] mask, input int hold_fr, input int rel_cyc);
        pressed = mask;
        wait_cyc(hold_fr * FRAME);
        pressed = '0;
        wait_cyc(rel_cyc);
    endtask

    task automatic buttons(input logic cm, input logic cl, input int len);
        commit_btn = cm;
        clear_btn  = cl;
        wait_cyc(len);
        commit_btn = 1'b0;
        clear_btn  = 1'b0;
        wait_cyc(20);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        wait_cyc(3);
        rst_n = 1'b1;
        // R10 reset state
        chk(display == 32'h0, "R10 display", display, 32'h0);
        chk(read_data == 32'h0, "R10 read_data", read_data, 32'h0);
        chk(row_drive == 4'b1110, "R10 row", {28'h0, row_drive}, 32'hE);
        // R1 rotation
        for (int i = 1; i <= 4; i++) begin
            logic [3:0] er;
            repeat (SLOT) @(posedge clk);
            @(negedge clk);
            er = ~(4'b1 << (i % 4));
            chk(row_drive == er, "R1 rotation", {28'h0, row_drive}, {28'h0, er});
        end
        // R3 / R5: directed digits
        for (int d = 1; d <= 3; d++) begin
            key(16'h1 << d, 4, 4 * FRAME);
            exp_buf = push(exp_buf, d[3:0]);
        end
        chk(display == exp_buf, "R3 shift-in 123", display, exp_buf);
        // R2: two columns on row 1 (keys 5 and 6) -> lower column wins
        key(16'h0060, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h5);
        chk(display == exp_buf, "R2 lowest column", display, exp_buf);
        // R2: rows 1 and 3 (keys 7 and 13) -> lower row wins
        key(16'h2080, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h7);
        chk(display == exp_buf, "R2 lowest row", display, exp_buf);
        // R4: long hold registers once
        key(16'h8000, 20, 4 * FRAME);
        exp_buf = push(exp_buf, 4'hF);
        chk(display == exp_buf, "R4 held once", display, exp_buf);
        // R4: short release gap (one empty scan at most) does not rearm
        key(16'h0200, 4, 24);
        key(16'h0200, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h9);
        chk(display == exp_buf, "R4 no rearm", display, exp_buf);
        // R6 commit
        buttons(1'b1, 1'b0, 12);
        exp_rd = exp_buf;
        chk(read_data == exp_rd, "R6 commit copy", read_data, exp_rd);
        // R7 / R5: new digit visible live, read data unchanged
        key(16'h0001, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h0);
        chk(display == exp_buf, "R5 live display", display, exp_buf);
        chk(read_data == exp_rd, "R7 hold read", read_data, exp_rd);
        // R6: commit held while a key is accepted acts only once
        commit_btn = 1'b1;
        wait_cyc(12);
        exp_rd = exp_buf;
        key(16'h0004, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h2);
        commit_btn = 1'b0;
        wait_cyc(20);
        chk(read_data == exp_rd, "R6 once per press", read_data, exp_rd);
        // R9: short glitches are ignored
        commit_btn = 1'b1; wait_cyc(2); commit_btn = 1'b0; wait_cyc(20);
        chk(read_data == exp_rd, "R9 commit glitch", read_data, exp_rd);
        clear_btn = 1'b1; wait_cyc(2); clear_btn = 1'b0; wait_cyc(20);
        chk(display == exp_buf, "R9 clear glitch", display, exp_buf);
        // R8 clear
        buttons(1'b0, 1'b1, 12);
        exp_buf = '0;
        chk(display == 32'h0, "R8 clear buffer", display, 32'h0);
        chk(read_data == exp_rd, "R8 read kept", read_data, exp_rd);
        // R11: commit and clear together
        key(16'h0008, 4, 4 * FRAME);
        exp_buf = push(exp_buf, 4'h3);
        buttons(1'b1, 1'b1, 12);
        exp_rd = exp_buf;
        exp_buf = '0;
        chk(read_data == exp_rd, "R11 pre-clear capture", read_data, exp_rd);
        chk(display == 32'h0, "R11 buffer cleared", display, 32'h0);
        // R3 overflow plus random mix
        for (int i = 0; i < 30; i++) begin
            logic [3:0] d;
            d = 4'($urandom_range(0, 15));
            key(16'h1 << d, 3, 3 * FRAME);
            exp_buf = push(exp_buf, d);
            chk(display == exp_buf, "R3 random digit", display, exp_buf);
            if ($urandom_range(0, 3) == 0) begin
                buttons(1'b1, 1'b0, 10);
                exp_rd = exp_buf;
                chk(read_data == exp_rd, "R6 random commit", read_data, exp_rd);
            end
        end
        chk(display == exp_buf, "R3 top digit dropped", display, exp_buf);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule